// File: doc/BRIEF.md
# Host-Target Mailbox Register Slave

This block is a register-bus slave that carries commands and replies between a processor and a simulation host. It holds two 64-bit words. The processor places commands in the outbound word and collects replies from the inbound word. Each word is reached as two 32-bit halves. A command takes effect only when the processor writes the upper half, after it has written a lower half that was accepted.

A finished outbound word is split into three fields: a device number in bits 63:56, a command in bits 55:48 and a 48-bit payload in bits 47:0. Device 0 with command 0 is the shutdown channel: an odd payload produces an exit pulse that carries the payload shifted right by one. Device 1 is a byte console. Command 1 sends a byte out. Command 0 arms a read, and the read is answered later, when a byte arrives on the console input stream. Every reply keeps the upper 16 bits of the request (its device and command) above a 48-bit response value. An unrecognised pair of device and command raises an error pulse. In every case the outbound word is cleared, which tells the processor that its command was taken.

The two base offsets are parameters. Each mailbox takes its base offset and the offset 4 above it. Reads are combinational.

Top module: `host_mailbox`

## Requirements
- R1: After reset, both mailbox words read zero, the arming tag is zero, no pulse output is high and con_rx_ready is high.
- R2: Address OUT_BASE reads outbound bits 31:0 and OUT_BASE+4 reads bits 63:32. IN_BASE and IN_BASE+4 do the same for the inbound word. Any other address reads zero, and a write to it changes nothing.
- R3: A write to OUT_BASE loads {32'h0, data} and opens the commit gate, but only while the whole outbound word is zero. If the word is nonzero, the write is ignored and the gate is closed.
- R4: A write to OUT_BASE+4 while the gate is open commits the word {data, outbound[31:0]}. One cycle later the outbound word reads zero and the gate is closed. A write to OUT_BASE+4 while the gate is closed is ignored.
- R5: A committed device 1, command 1 produces a one-cycle con_tx_valid pulse with con_tx_byte equal to payload bits 7:0. The inbound word becomes {request[63:48], 48'h100 | byte}.
- R6: A committed device 1, command 0 stores request bits 63:48 as the arming tag. It leaves the inbound word unchanged and produces no pulse.
- R7: A byte accepted on the console input makes the inbound word {tag, 48'h100 | byte}.
- R8: con_rx_ready is high only when the inbound word is zero, no inbound write is in progress, and no bus write to any of the four mailbox addresses happens in that cycle.
- R9: A committed device 0, command 0 sets the inbound word to {request[63:48], 48'h0}. If payload bit 0 is 1, it also gives a one-cycle exit_valid pulse with exit_code equal to payload bits 47:1. If bit 0 is 0, no pulse is given.
- R10: Any other device and command pair gives a one-cycle cmd_error pulse and clears the outbound word. The inbound word is left unchanged.
- R11: A write to IN_BASE loads {32'h0, data} into the inbound word and marks an inbound write in progress. A write to IN_BASE+4 replaces bits 63:32 and ends the in-progress state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| con_tx_valid | output | 1 | One-cycle pulse for a console output byte |
| con_tx_byte | output | 8 | Console output byte |
| con_rx_valid | input | 1 | A console input byte is offered |
| con_rx_byte | input | 8 | Console input byte |
| con_rx_ready | output | 1 | The block accepts the offered byte in this cycle |
| exit_valid | output | 1 | One-cycle exit report pulse |
| exit_code | output | 47 | Exit code, valid with exit_valid |
| cmd_error | output | 1 | One-cycle pulse for an unknown device or command |

## Verification
The bench builds the block with a 12-bit address, the outbound mailbox at 0x040 and the inbound mailbox at 0x010. Placing the inbound word below the outbound one shows that the decode does not depend on which base is lower. It also leaves free addresses both between the two mailboxes and above them, so writes that hit no register can be tested. With these offsets, a console byte can be offered in the same cycle as a write to a mailbox half, and an all-ones payload exercises the full 47-bit exit code.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int HALF_W = 32;
  localparam int WORD_W = 2 * HALF_W;
  localparam int PAY_W  = 48;
  localparam int TAG_W  = WORD_W - PAY_W;
  localparam int BYTE_W = 8;
  localparam int CODE_W = PAY_W - 1;

  localparam logic [7:0] DEV_SYS  = 8'h00;
  localparam logic [7:0] DEV_CON  = 8'h01;
  localparam logic [7:0] CMD_HALT = 8'h00;
  localparam logic [7:0] CMD_GET  = 8'h00;
  localparam logic [7:0] CMD_PUT  = 8'h01;

  typedef enum logic [2:0] {
    ACT_EXIT,
    ACT_ZERO,
    ACT_PEND,
    ACT_PUTC,
    ACT_BAD
  } mbx_act_e;

  typedef struct packed {
    mbx_act_e              act;
    logic [PAY_W-1:0]      resp;
    logic [CODE_W-1:0]     code;
    logic [BYTE_W-1:0]     tx_byte;
  } mbx_dec_t;
endpackage

// File: rtl/mbx_addr_dec.sv
`timescale 1ns/1ps
module mbx_addr_dec #(
  parameter int               ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] OUT_BASE = 'h000,
  parameter logic [ADDR_W-1:0] IN_BASE  = 'h008
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        hit
);
  // slot 0: outbound low, 1: outbound high, 2: inbound low, 3: inbound high
  for (genvar g = 0; g < 4; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] BASE = (g < 2) ? OUT_BASE : IN_BASE;
    localparam logic [ADDR_W-1:0] SLOT = BASE + ADDR_W'(4 * (g % 2));
    assign hit[g] = (addr == SLOT);
  end
endmodule

// File: rtl/mbx_cmd_dec.sv
`timescale 1ns/1ps
module mbx_cmd_dec
  import mbx_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output mbx_dec_t          dec
);
  logic [7:0] dev;
  logic [7:0] cmd;

  assign dev = word[63:56];
  assign cmd = word[55:48];

  always_comb begin
    dec.act     = ACT_BAD;
    dec.resp    = '0;
    dec.code    = word[PAY_W-1:1];
    dec.tx_byte = word[BYTE_W-1:0];
    if (dev == DEV_SYS) begin
      if (cmd == CMD_HALT) dec.act = word[0] ? ACT_EXIT : ACT_ZERO;
    end else if (dev == DEV_CON) begin
      if (cmd == CMD_GET) begin
        dec.act = ACT_PEND;
      end else if (cmd == CMD_PUT) begin
        dec.act  = ACT_PUTC;
        dec.resp = {{(PAY_W-BYTE_W-1){1'b0}}, 1'b1, word[BYTE_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/host_mailbox.sv
`timescale 1ns/1ps
module host_mailbox
  import mbx_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] OUT_BASE = 'h000,
  parameter logic [ADDR_W-1:0] IN_BASE  = 'h008
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [HALF_W-1:0]  bus_wdata,
  output logic [HALF_W-1:0]  bus_rdata,
  output logic               con_tx_valid,
  output logic [BYTE_W-1:0]  con_tx_byte,
  input  logic               con_rx_valid,
  input  logic [BYTE_W-1:0]  con_rx_byte,
  output logic               con_rx_ready,
  output logic               exit_valid,
  output logic [CODE_W-1:0]  exit_code,
  output logic               cmd_error
);
  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rsync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  logic [3:0]        hit;
  logic [WORD_W-1:0] out_q, out_d, in_q, in_d, word_full;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic              gate_q, gate_d, prog_q, prog_d;
  logic              out_en, in_en, tag_en;
  logic              tx_d, exit_d, err_d;
  logic              wr_olo, wr_ohi, wr_ilo, wr_ihi, commit, touch, rx_take;
  mbx_dec_t          dec;

  mbx_addr_dec #(.ADDR_W(ADDR_W), .OUT_BASE(OUT_BASE), .IN_BASE(IN_BASE)) u_adec (
    .addr (bus_addr),
    .hit  (hit)
  );

  assign word_full = {bus_wdata, out_q[HALF_W-1:0]};

  mbx_cmd_dec u_cdec (
    .word (word_full),
    .dec  (dec)
  );

  assign wr_olo  = bus_we & hit[0];
  assign wr_ohi  = bus_we & hit[1];
  assign wr_ilo  = bus_we & hit[2];
  assign wr_ihi  = bus_we & hit[3];
  assign commit  = wr_ohi & gate_q;
  assign touch   = bus_we & (|hit);
  assign con_rx_ready = (in_q == '0) & ~prog_q & ~touch;
  assign rx_take = con_rx_valid & con_rx_ready;

  // next-state
  always_comb begin
    out_d  = out_q;
    in_d   = in_q;
    tag_d  = tag_q;
    gate_d = gate_q;
    prog_d = prog_q;
    out_en = 1'b0;
    in_en  = 1'b0;
    tag_en = 1'b0;
    tx_d   = 1'b0;
    exit_d = 1'b0;
    err_d  = 1'b0;
    if (wr_olo) begin
      if (out_q == '0) begin
        gate_d = 1'b1;
        out_d  = {{HALF_W{1'b0}}, bus_wdata};
        out_en = 1'b1;
      end else begin
        gate_d = 1'b0;
      end
    end
    if (commit) begin
      gate_d = 1'b0;
      out_d  = '0;
      out_en = 1'b1;
      case (dec.act)
        ACT_EXIT: begin
          in_d   = {word_full[WORD_W-1:PAY_W], dec.resp};
          in_en  = 1'b1;
          exit_d = 1'b1;
        end
        ACT_ZERO: begin
          in_d  = {word_full[WORD_W-1:PAY_W], dec.resp};
          in_en = 1'b1;
        end
        ACT_PEND: begin
          tag_d  = word_full[WORD_W-1:PAY_W];
          tag_en = 1'b1;
        end
        ACT_PUTC: begin
          in_d  = {word_full[WORD_W-1:PAY_W], dec.resp};
          in_en = 1'b1;
          tx_d  = 1'b1;
        end
        default: err_d = 1'b1;
      endcase
    end
    if (wr_ilo) begin
      prog_d = 1'b1;
      in_d   = {{HALF_W{1'b0}}, bus_wdata};
      in_en  = 1'b1;
    end
    if (wr_ihi) begin
      prog_d = 1'b0;
      in_d   = {bus_wdata, in_q[HALF_W-1:0]};
      in_en  = 1'b1;
    end
    if (rx_take) begin
      in_d  = {tag_q, {(PAY_W-BYTE_W-1){1'b0}}, 1'b1, con_rx_byte};
      in_en = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_q        <= '0;
      in_q         <= '0;
      tag_q        <= '0;
      gate_q       <= 1'b0;
      prog_q       <= 1'b0;
      con_tx_valid <= 1'b0;
      con_tx_byte  <= '0;
      exit_valid   <= 1'b0;
      exit_code    <= '0;
      cmd_error    <= 1'b0;
    end else begin
      if (out_en) out_q <= out_d;
      if (in_en)  in_q  <= in_d;
      if (tag_en) tag_q <= tag_d;
      gate_q       <= gate_d;
      prog_q       <= prog_d;
      con_tx_valid <= tx_d;
      exit_valid   <= exit_d;
      cmd_error    <= err_d;
      if (tx_d)   con_tx_byte <= dec.tx_byte;
      if (exit_d) exit_code   <= dec.code;
    end
  end

  always_comb begin
    unique case (1'b1)
      hit[0]:  bus_rdata = out_q[HALF_W-1:0];
      hit[1]:  bus_rdata = out_q[WORD_W-1:HALF_W];
      hit[2]:  bus_rdata = in_q[HALF_W-1:0];
      hit[3]:  bus_rdata = in_q[WORD_W-1:HALF_W];
      default: bus_rdata = '0;
    endcase
  end

  AST_LO_REJECT: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_olo && out_q != '0) |=> ($stable(out_q) && !gate_q)); // R3
  AST_OUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_q)
    commit |=> (out_q == '0)); // R4
  AST_TX_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_q)
    con_tx_valid |-> $past(bus_we && hit[1] && gate_q)); // R5
  AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_q)
    rx_take |=> (in_q[8] && in_q[7:0] == $past(con_rx_byte))); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({con_tx_valid, exit_valid, cmd_error})); // R9
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_error |-> (in_q == $past(in_q))); // R10
endmodule

// File: tb/tb_host_mailbox.sv
`timescale 1ns/1ps
module tb_host_mailbox;
  localparam int          AW = 12;
  localparam logic [11:0] OB = 12'h040;
  localparam logic [11:0] IB = 12'h010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        con_tx_valid;
  logic [7:0]  con_tx_byte;
  logic        con_rx_valid = 1'b0;
  logic [7:0]  con_rx_byte = '0;
  logic        con_rx_ready;
  logic        exit_valid;
  logic [46:0] exit_code;
  logic        cmd_error;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;
  bit live = 1'b0;

  always #4 clk = ~clk;

  host_mailbox #(.ADDR_W(AW), .OUT_BASE(OB), .IN_BASE(IB)) dut (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .con_tx_valid, .con_tx_byte, .con_rx_valid, .con_rx_byte, .con_rx_ready,
    .exit_valid, .exit_code, .cmd_error
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [63:0] m_out, m_in, m_pend, w;
  bit          m_gate, m_prog, m_tx, m_ex, m_err, m_touch, m_take;
  logic [7:0]  m_txb;
  logic [46:0] m_exc;

  function automatic bit is_mbx(input logic [11:0] a);
    return (a == OB) || (a == OB + 12'd4) || (a == IB) || (a == IB + 12'd4);
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a == OB) return m_out[31:0];
    if (a == OB + 12'd4) return m_out[63:32];
    if (a == IB) return m_in[31:0];
    if (a == IB + 12'd4) return m_in[63:32];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_in = 0; m_pend = 0; m_gate = 0; m_prog = 0;
      m_tx = 0; m_ex = 0; m_err = 0; m_txb = 0; m_exc = 0;
    end else begin
      m_tx = 0; m_ex = 0; m_err = 0;
      m_touch = bus_we && is_mbx(bus_addr);
      m_take  = con_rx_valid && m_in == 0 && !m_prog && !m_touch;
      if (bus_we && bus_addr == OB) begin
        if (m_out == 0) begin m_gate = 1; m_out = {32'h0, bus_wdata}; end
        else m_gate = 0;
      end else if (bus_we && bus_addr == OB + 12'd4 && m_gate) begin
        w = {bus_wdata, m_out[31:0]};
        m_out = 0; m_gate = 0;
        if (w[63:56] == 0 && w[55:48] == 0) begin
          m_in = {w[63:48], 48'h0};
          if (w[0]) begin m_ex = 1; m_exc = w[47:1]; end
        end else if (w[63:56] == 1 && w[55:48] == 0) begin
          m_pend = w;
        end else if (w[63:56] == 1 && w[55:48] == 1) begin
          m_tx = 1; m_txb = w[7:0]; m_in = {w[63:48], 48'h100 | 48'(w[7:0])};
        end else m_err = 1;
      end else if (bus_we && bus_addr == IB) begin
        m_prog = 1; m_in = {32'h0, bus_wdata};
      end else if (bus_we && bus_addr == IB + 12'd4) begin
        m_prog = 0; m_in[63:32] = bus_wdata;
      end
      if (m_take) m_in = {m_pend[63:48], 48'h100 | 48'(con_rx_byte)};
    end
  end

  // compare on every clock, away from the edges
  always @(negedge clk) begin
    if (live) begin
      #2;
      chk("R2 rdata vs model", 64'(bus_rdata), 64'(m_read(bus_addr)));
      chk("R8 rx_ready vs model", 64'(con_rx_ready),
          64'(m_in == 0 && !m_prog && !(bus_we && is_mbx(bus_addr))));
      chk("R5 tx_valid vs model", 64'(con_tx_valid), 64'(m_tx));
      if (m_tx) chk("R5 tx_byte vs model", 64'(con_tx_byte), 64'(m_txb));
      chk("R9 exit_valid vs model", 64'(exit_valid), 64'(m_ex));
      if (m_ex) chk("R9 exit_code vs model", 64'(exit_code), 64'(m_exc));
      chk("R10 cmd_error vs model", 64'(cmd_error), 64'(m_err));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk);
    con_rx_valid = 1'b1; con_rx_byte = b;
    #1;
    while (!con_rx_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    con_rx_valid = 1'b0;
  endtask

  task automatic clear_in();
    wr(IB, 32'h0);
    wr(IB + 12'd4, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(OB, 0, "R1 out lo"); rd(OB + 12'd4, 0, "R1 out hi");
    rd(IB, 0, "R1 in lo");  rd(IB + 12'd4, 0, "R1 in hi");
    chk("R1 rx_ready", 64'(con_rx_ready), 64'd1);
    chk("R1 pulses", 64'({con_tx_valid, exit_valid, cmd_error}), 64'd0);

    // R3/R4/R5 console put of 'A'
    wr(OB, 32'h0000_0041);
    rd(OB, 32'h41, "R3 out lo loaded");
    wr(OB + 12'd4, 32'h0101_0000);
    #1;
    chk("R5 tx pulse", 64'({con_tx_valid, con_tx_byte}), 64'h141);
    rd(OB, 0, "R4 out cleared");
    rd(IB, 32'h0000_0141, "R5 in lo");
    rd(IB + 12'd4, 32'h0101_0000, "R5 in hi");
    chk("R8 ready low when inbound full", 64'(con_rx_ready), 64'd0);

    // R11 inbound writes
    wr(IB, 32'h0);
    #1;
    chk("R11 ready low while in progress", 64'(con_rx_ready), 64'd0);
    rd(IB + 12'd4, 32'h0, "R11 low write cleared upper half");
    wr(IB + 12'd4, 32'h0);
    #1;
    chk("R11 ready back after high write", 64'(con_rx_ready), 64'd1);

    // R4 high write with gate closed after commit
    wr(OB + 12'd4, 32'h0101_0000);
    #1;
    chk("R4 no commit without gate", 64'(con_tx_valid), 64'd0);
    rd(OB + 12'd4, 0, "R4 ignored high write");

    // R6/R7 armed read, then byte arrives
    wr(OB, 32'h0);
    wr(OB + 12'd4, 32'h0100_0000);
    rd(IB, 0, "R6 inbound unchanged");
    rd(OB + 12'd4, 0, "R6 out cleared");
    rx(8'h5A);
    rd(IB, 32'h0000_015A, "R7 in lo");
    rd(IB + 12'd4, 32'h0100_0000, "R7 in hi tag");
    clear_in();

    // R8 byte offered during a mailbox write is deferred by one cycle
    fork
      wr(IB + 12'd4, 32'h0);
      rx(8'h33);
    join
    rd(IB, 32'h0000_0133, "R8 deferred byte accepted");
    clear_in();

    // R9 exit with odd payload, then even payload, then full-width code
    wr(OB, 32'h0000_000B);
    wr(OB + 12'd4, 32'h0);
    #1;
    chk("R9 exit code 5", 64'({exit_valid, exit_code}), {16'h0, 1'b1, 47'd5});
    wr(OB, 32'h0000_0004);
    wr(OB + 12'd4, 32'h0);
    #1;
    chk("R9 even payload no exit", 64'(exit_valid), 64'd0);
    rd(IB, 0, "R9 inbound zero reply");
    wr(OB, 32'hFFFF_FFFF);
    wr(OB + 12'd4, 32'h0000_FFFF);
    #1;
    chk("R9 full code", 64'({exit_valid, exit_code}), {16'h0, 1'b1, 47'h7FFF_FFFF_FFFF});

    // R10 unknown device and unknown command leave inbound alone
    wr(OB, 32'h0000_0042);
    wr(OB + 12'd4, 32'h0101_0000);
    wr(OB, 32'h0000_0012);
    wr(OB + 12'd4, 32'h0200_0000);
    #1;
    chk("R10 error on device 2", 64'(cmd_error), 64'd1);
    rd(IB, 32'h0000_0142, "R10 inbound kept");
    rd(OB, 0, "R10 out cleared");
    wr(OB, 32'h0000_0001);
    wr(OB + 12'd4, 32'h0105_0000);
    #1;
    chk("R10 error on console command 5", 64'(cmd_error), 64'd1);
    rd(IB + 12'd4, 32'h0101_0000, "R10 inbound hi kept");

    // R2 unmapped address
    wr(12'h100, 32'hDEAD_BEEF);
    rd(12'h100, 0, "R2 unmapped reads zero");
    rd(OB + 12'd8, 0, "R2 gap reads zero");
    rd(OB, 0, "R2 unmapped write no effect out");
    rd(IB, 32'h0000_0142, "R2 unmapped write no effect in");

    // R3 low write rejected when outbound nonzero, gate closed
    wr(OB, 32'h0000_0077);
    wr(OB, 32'h0000_0099);
    rd(OB, 32'h77, "R3 rejected low write");
    wr(OB + 12'd4, 32'h0101_0000);
    #1;
    chk("R3 gate closed blocks commit", 64'(con_tx_valid), 64'd0);
    rd(OB, 32'h77, "R3 outbound still held");

    repeat (3) @(negedge clk);
    done = 1'b1;
    live = 1'b0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule